// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side master for a three-wire voltage-output DAC port. A client hands it a 2-bit output mode and a 16-bit conversion code through a valid/ready handshake. The block packs them into a 24-bit frame: six padding zeros, the two mode bits, then the code. It shifts the frame out MSB first on a frame-select line (`syncN`), a serial clock (`sclk`) and a data line (`sdata`).

The serial clock idles low. The block changes data on each rising clock edge, so the slave can sample it on the following falling edge. Every half period is a fixed number of system clocks, so the serial clock rate and the data setup and hold margins come from one parameter. The frame may be split into 8-bit bursts with extra low-clock pauses between them, and `syncN` stays low for the whole frame. After the 24th falling edge the block waits one more half period and then raises `syncN`. It then holds `syncN` high for a programmable gap before it accepts the next request. `done` pulses once per frame when `syncN` rises. `busy` covers the whole transaction, including the gap.

Top module: `sdac_host_ctrl`

## Requirements
- R1: Out of reset, the outputs are `syncN`=1, `sclk`=0, `sdata`=0, `busy`=0, `done`=0 and `reqReady`=1.
- R2: Each frame is 24 bits, sent MSB first. Bits 23..18 are 0, bit 17 is `reqMode[1]`, bit 16 is `reqMode[0]`, and bits 15..0 are `reqCode[15:0]`.
- R3: `sdata` changes only in the cycle in which `sclk` rises, or in the cycle in which `syncN` rises (it returns to 0 then). It is therefore stable across every falling edge.
- R4: Each high phase of `sclk` lasts exactly CLK_DIV system clocks. Each low phase inside a frame also lasts exactly CLK_DIV clocks. This includes the lead-in from the `syncN` fall to the first rising edge.
- R5: `syncN` rises only after exactly 24 falling `sclk` edges since it fell, and `sclk` is low whenever `syncN` is high.
- R6: Between two frames, `syncN` stays high for at least GAP_CYCLES system clocks.
- R7: A request is taken only when `reqValid` and `reqReady` are both high in a cycle. `syncN` falls and `busy` rises in the next cycle. Values on `reqMode` and `reqCode` after that cycle do not alter the frame in flight.
- R8: `done` is high for exactly one cycle per frame: the first cycle in which `syncN` is high again.
- R9: When BYTE_PAUSE > 0, the low phase that follows the 8th or the 16th falling edge lasts CLK_DIV+BYTE_PAUSE clocks, and `syncN` stays low through it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqMode | input | MODE_W (2) | Output mode bits placed ahead of the code |
| reqCode | input | CODE_W (16) | Conversion code |
| syncN | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data, changes on rising `sclk` |
| busy | output | 1 | Transaction in progress, including the inter-frame gap |
| done | output | 1 | One-cycle pulse when `syncN` returns high |

## Verification
The bound checker watches the waveform rules on every cycle: the length of each high and low half period, that data moves only with a rising clock or the end of a frame, the count of falling edges before the frame select is released, the minimum high gap, the alignment of the completion pulse, and the reaction to an accepted request. Whether the bits that leave the block are the mode and code that were accepted, in the right order and with zero padding, only the bench's scoreboard can show, because it rebuilds each word from the line. The same holds for the longer pauses at the burst boundaries and for the claim that input changes during a frame are ignored.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_PAUSE,
    ST_GAP
  } sdac_state_e;

  // strobes from sequencer to shift datapath
  typedef struct packed {
    logic loadFrame;  // capture request, pull frame select low
    logic sclkRise;   // drive clock high and present the next bit
    logic sclkFall;   // drive clock low (slave samples here)
    logic endFrame;   // release frame select, park data low
  } sdac_strobe_t;

endpackage

// File: rtl/sdac_seq_ctrl.sv
module sdac_seq_ctrl
  import sdac_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYCLES = 4,
  parameter int BYTE_PAUSE = 0,
  parameter int FRAME_BITS = 24,
  parameter int BURST_BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         busy,
  output logic         done,
  output sdac_strobe_t strobe
);

  localparam int MAX_A    = (CLK_DIV > GAP_CYCLES) ? CLK_DIV : GAP_CYCLES;
  localparam int MAX_WAIT = (MAX_A > BYTE_PAUSE) ? MAX_A : BYTE_PAUSE;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int BIT_W    = $clog2(FRAME_BITS + 1);

  localparam logic [CNT_W-1:0] HALF_LOAD  = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD   = CNT_W'(GAP_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAUSE_LOAD = CNT_W'((BYTE_PAUSE > 0) ? BYTE_PAUSE - 1 : 0);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_BITS);

  sdac_state_e      state, stateNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic [BIT_W-1:0] bitCnt, bitCntNext;
  logic             atBurstEdge;
  logic             waitDone;

  assign waitDone = (waitCnt == '0);

  // burst boundary detection only exists when a pause is configured
  generate
    if (BYTE_PAUSE > 0) begin : g_burst
      assign atBurstEdge = (bitCnt != '0) &&
                           ((bitCnt % BIT_W'(BURST_BITS)) == '0);
    end else begin : g_noBurst
      assign atBurstEdge = 1'b0;
    end
  endgenerate

  always_comb begin
    stateNext   = state;
    waitCntNext = waitCnt;
    bitCntNext  = bitCnt;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadFrame = 1'b1;
          stateNext        = ST_LEAD;
          waitCntNext      = HALF_LOAD;
          bitCntNext       = '0;
        end
      end
      ST_LEAD, ST_PAUSE: begin
        if (waitDone) begin
          strobe.sclkRise = 1'b1;
          stateNext       = ST_HIGH;
          waitCntNext     = HALF_LOAD;
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      ST_HIGH: begin
        if (waitDone) begin
          strobe.sclkFall = 1'b1;
          bitCntNext      = bitCnt + 1'b1;
          stateNext       = ST_LOW;
          waitCntNext     = HALF_LOAD;
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      ST_LOW: begin
        if (waitDone) begin
          if (bitCnt == LAST_BIT) begin
            strobe.endFrame = 1'b1;
            stateNext       = ST_GAP;
            waitCntNext     = GAP_LOAD;
          end else if (atBurstEdge) begin
            stateNext   = ST_PAUSE;
            waitCntNext = PAUSE_LOAD;
          end else begin
            strobe.sclkRise = 1'b1;
            stateNext       = ST_HIGH;
            waitCntNext     = HALF_LOAD;
          end
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      ST_GAP: begin
        if (waitDone) begin
          stateNext = ST_IDLE;
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      bitCnt  <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
      bitCnt  <= bitCntNext;
      done    <= strobe.endFrame;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/sdac_shift_dp.sv
module sdac_shift_dp
  import sdac_pkg::*;
#(
  parameter int MODE_W     = 2,
  parameter int CODE_W     = 16,
  parameter int FRAME_BITS = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdac_strobe_t      strobe,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [CODE_W-1:0] reqCode,
  output logic              syncN,
  output logic              sclk,
  output logic              sdata
);

  localparam int PAD_W = FRAME_BITS - MODE_W - CODE_W;

  logic [FRAME_BITS-1:0] frameWord;
  logic [FRAME_BITS-1:0] shiftReg;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frameWord = {{PAD_W{1'b0}}, reqMode, reqCode};
    end else begin : g_noPad
      assign frameWord = {reqMode, reqCode};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      syncN    <= 1'b1;
      sclk     <= 1'b0;
      sdata    <= 1'b0;
    end else begin
      if (strobe.loadFrame) begin
        shiftReg <= frameWord;
        syncN    <= 1'b0;
      end else if (strobe.sclkRise) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
        sclk     <= 1'b1;
        sdata    <= shiftReg[FRAME_BITS-1];
      end else if (strobe.sclkFall) begin
        sclk <= 1'b0;
      end else if (strobe.endFrame) begin
        syncN <= 1'b1;
        sdata <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdac_host_ctrl.sv
module sdac_host_ctrl
  import sdac_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYCLES = 4,
  parameter int BYTE_PAUSE = 0,
  parameter int MODE_W     = 2,
  parameter int CODE_W     = 16,
  parameter int FRAME_BITS = 24,
  parameter int BURST_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [CODE_W-1:0] reqCode,
  output logic              syncN,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              done
);

  sdac_strobe_t strobe;

  sdac_seq_ctrl #(
    .CLK_DIV   (CLK_DIV),
    .GAP_CYCLES(GAP_CYCLES),
    .BYTE_PAUSE(BYTE_PAUSE),
    .FRAME_BITS(FRAME_BITS),
    .BURST_BITS(BURST_BITS)
  ) seq_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .busy    (busy),
    .done    (done),
    .strobe  (strobe)
  );

  sdac_shift_dp #(
    .MODE_W    (MODE_W),
    .CODE_W    (CODE_W),
    .FRAME_BITS(FRAME_BITS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .reqMode(reqMode),
    .reqCode(reqCode),
    .syncN  (syncN),
    .sclk   (sclk),
    .sdata  (sdata)
  );

endmodule

// File: rtl/sdac_host_chk.sv
module sdac_host_chk #(
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYCLES = 4,
  parameter int FRAME_BITS = 24
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic syncN,
  input logic sclk,
  input logic sdata,
  input logic busy,
  input logic done
);

  logic [15:0] hiCnt, loCnt, gapCnt, fallCnt;
  logic        sclkQ;

  // run-length counters observed from the ports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt   <= '0;
      loCnt   <= '0;
      gapCnt  <= 16'(GAP_CYCLES);
      fallCnt <= '0;
      sclkQ   <= 1'b0;
    end else begin
      sclkQ  <= sclk;
      hiCnt  <= sclk ? ((hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 1'b1) : '0;
      loCnt  <= (!sclk && !syncN) ? ((loCnt == 16'hFFFF) ? loCnt : loCnt + 1'b1) : '0;
      gapCnt <= syncN ? ((gapCnt == 16'hFFFF) ? gapCnt : gapCnt + 1'b1) : '0;
      if (syncN)               fallCnt <= '0;
      else if (sclkQ && !sclk) fallCnt <= fallCnt + 1'b1;
    end
  end

  p_data_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdata) |-> ($rose(sclk) || $rose(syncN)));

  p_high_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (hiCnt == 16'(CLK_DIV)));

  p_low_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> (loCnt >= 16'(CLK_DIV)));

  p_edge_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncN) |-> (fallCnt == 16'(FRAME_BITS)));

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    syncN |-> !sclk);

  p_gap_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncN) |-> (gapCnt >= 16'(GAP_CYCLES)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !syncN));

  p_done_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncN) |-> done);

  p_done_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(syncN));

endmodule

bind sdac_host_ctrl sdac_host_chk #(
  .CLK_DIV   (CLK_DIV),
  .GAP_CYCLES(GAP_CYCLES),
  .FRAME_BITS(FRAME_BITS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .syncN   (syncN),
  .sclk    (sclk),
  .sdata   (sdata),
  .busy    (busy),
  .done    (done)
);

// File: tb/sdac_host_ctrl_tb.sv
module sdac_host_ctrl_tb_top;

  localparam int DIV   = 2;
  localparam int GAP   = 5;
  localparam int PAUSE = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = '0;
  logic [15:0] reqCode = '0;
  logic        reqReady, syncN, sclk, sdata, busy, done;

  always #5 clk = ~clk;

  sdac_host_ctrl #(
    .CLK_DIV   (DIV),
    .GAP_CYCLES(GAP),
    .BYTE_PAUSE(PAUSE)
  ) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqMode (reqMode),
    .reqCode (reqCode),
    .syncN   (syncN),
    .sclk    (sclk),
    .sdata   (sdata),
    .busy    (busy),
    .done    (done)
  );

  int checks = 0;
  int fails  = 0;
  int framesSeen = 0;
  logic [23:0] expQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: waits for ready, presents one request, then scrambles inputs
  task automatic sendFrame(input logic [1:0] m, input logic [15:0] c);
    do begin @(posedge clk); #1; end while (!reqReady);
    reqValid = 1'b1; reqMode = m; reqCode = c;
    expQ.push_back({6'b0, m, c});
    @(posedge clk); #1;
    reqValid = 1'b0; reqMode = ~m; reqCode = c ^ 16'h5A5A;  // R7: must not leak
  endtask

  // driver: raises valid while the block is still busy and holds it
  task automatic sendHeld(input logic [1:0] m, input logic [15:0] c);
    @(posedge clk); #1;
    reqValid = 1'b1; reqMode = m; reqCode = c;
    expQ.push_back({6'b0, m, c});
    while (!reqReady) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    reqValid = 1'b0; reqCode = 16'hDEAD; reqMode = 2'b01;
  endtask

  // monitor / scoreboard
  logic prevSclk = 1'b0, prevSync = 1'b1, prevSdata = 1'b0;
  int hiRun = 0, loRun = 0, gapRun = 1000, falls = 0;
  logic [23:0] word = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (reqValid && reqReady)
        check(syncN && !busy, "R7 accept only when idle", {syncN, busy}, 2'b10);
      if (!syncN && prevSync) begin
        check(gapRun >= GAP, "R6 sync high gap", gapRun, GAP);
        falls = 0;
        word  = '0;
      end
      if (!sclk && prevSclk) begin
        check(hiRun == DIV, "R4 high phase", hiRun, DIV);
        falls++;
        word = {word[22:0], sdata};
      end
      if (sclk && !prevSclk) begin
        if (falls == 8 || falls == 16)
          check(loRun == DIV + PAUSE && !syncN, "R9 burst pause", loRun, DIV + PAUSE);
        else
          check(loRun == DIV, "R4 low phase", loRun, DIV);
      end
      if (sdata != prevSdata)
        check((sclk && !prevSclk) || (syncN && !prevSync), "R3 data moved off rising edge",
              {sclk, prevSclk}, 2'b10);
      if (syncN && !prevSync) begin
        logic [23:0] exp;
        framesSeen++;
        check(falls == 24, "R5 falling edges per frame", falls, 24);
        check(!sclk, "R5 clock low at release", sclk, 0);
        check(done, "R8 done with sync rise", done, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected frame", word, 0);
        end else begin
          exp = expQ.pop_front();
          check(word == exp, "R2 frame content", word, exp);
        end
      end else if (done) begin
        check(1'b0, "R8 stray done", done, 0);
      end
      hiRun  = sclk ? hiRun + 1 : 0;
      loRun  = (!sclk && !syncN) ? loRun + 1 : 0;
      gapRun = syncN ? gapRun + 1 : 0;
      prevSclk  = sclk;
      prevSync  = syncN;
      prevSdata = sdata;
    end
  end

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset levels
    check(syncN === 1'b1, "R1 syncN reset", syncN, 1);
    check(sclk === 1'b0 && sdata === 1'b0, "R1 sclk/sdata reset", {sclk, sdata}, 0);
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done reset", {busy, done}, 0);
    check(reqReady === 1'b1, "R1 ready reset", reqReady, 1);

    fork
      begin
        sendFrame(2'b00, 16'h0000);
        sendFrame(2'b11, 16'hFFFF);
        sendFrame(2'b01, 16'hA5C3);
        sendFrame(2'b10, 16'h8001);
        sendFrame(2'b00, 16'h7FFE);
        sendHeld (2'b10, 16'h1234);   // R7: held valid waits for idle
        sendHeld (2'b11, 16'h00FF);
        while (expQ.size() != 0) @(posedge clk);
        repeat (20) @(posedge clk);
      end
      begin
        repeat (50000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;

    if (timedOut) check(1'b0, "watchdog expired", 0, 1);
    @(negedge clk);
    check(framesSeen == 7, "R2 frame count", framesSeen, 7);
    check(!busy && reqReady && syncN, "R1 idle after traffic", {busy, reqReady, syncN}, 3'b011);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule